// File: doc/BRIEF.md
# Burst-Addressed Synchronous Memory Port

This block is one clocked access port of a static word memory that carries its own burst address counter. Each word is 18 bits wide and is split into two 9-bit byte lanes. On every rising clock edge the port picks an access address. It can clear it to zero, take the address from the address pins, step the stored address by one, or keep the stored address. It then reads or writes the word at that address. A write can be limited to either byte lane.

Two chip enables (one active-low, one active-high) and a read/write select qualify each access. An output enable decides whether read data is presented. A mode pin selects between two read latencies. In flow-through mode the data follows the addressing edge directly. In pipelined mode one more register stage is added. Reads are reported on an 18-bit data bus with a valid flag, and the flag stands in for the tri-state condition of the outputs. The memory depth is set by an address-width parameter.

Top module: `bsram_port`

## Requirements
- R1: While `clr_n` is low at a rising edge, the access address and the stored counter become 0, whatever `ld_n` and `adv_n` are.
- R2: When `clr_n` is high and `ld_n` is low, `ext_addr` is the access address for that same edge and is stored. This happens regardless of `cs_n`, `cs` and `lane_n`.
- R3: When `clr_n` and `ld_n` are high and `adv_n` is low, the access address is the stored address plus one, even when the chip is deselected or both lanes are off. The highest address wraps to 0.
- R4: When `clr_n`, `ld_n` and `adv_n` are all high, the stored address is reused unchanged.
- R5: A write happens only when `cs_n`=0, `cs`=1 and `wr_n`=0. `lane_n[0]`=0 updates bits 8:0 and `lane_n[1]`=0 updates bits 17:9. A lane whose enable is 1 keeps its old contents.
- R6: A read is reported (`rvalid`=1, `rdata` = stored word) only when `cs_n`=0, `cs`=1, `wr_n`=1, `oe_n`=0 and at least one `lane_n` bit is 0. In every other cycle `rvalid` is 0, including when the output is disabled, the chip is deselected, or the cycle is a write. All of these inputs are sampled at the addressing edge.
- R7: With `pipe_mode`=0, `rdata` and `rvalid` for an access are visible right after its addressing edge, until the next edge.
- R8: With `pipe_mode`=1, `rdata` and `rvalid` appear one clock later than in R7, and data and flag stay aligned.
- R9: A synchronous `por` pulse sets the stored address to 0 and `rvalid` to 0. Memory contents are not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock, rising edge active |
| por | input | 1 | Synchronous power-on reset, active high |
| ext_addr | input | ADDR_W | External address |
| ld_n | input | 1 | Address strobe, active low |
| adv_n | input | 1 | Counter advance, active low |
| clr_n | input | 1 | Counter clear, active low |
| cs_n | input | 1 | Chip enable, active low |
| cs | input | 1 | Chip enable, active high |
| wr_n | input | 1 | 1 = read, 0 = write |
| lane_n | input | 2 | Byte lane enables, active low |
| oe_n | input | 1 | Output enable, active low |
| pipe_mode | input | 1 | 0 = flow-through, 1 = pipelined read |
| wdata | input | 18 | Write data |
| rdata | output | 18 | Read data |
| rvalid | output | 1 | Read data is being driven |

## Verification
Address selection and the memory access are resolved on the same edge. A load, a step or a clear therefore decides which word is read or written in that very cycle. The bench drives reads and writes together with `ld_n`, `adv_n` and `clr_n`, and applies several of these controls at once to test the priority. A scoreboard computes the address and word from its own model and expects them one or two edges later, depending on the mode. The counter control is also exercised while the chip is deselected. The stepped or loaded address is then made visible by an ordinary read that uses the hold command.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
    localparam int LANE_W = 9;
    localparam int LANES  = 2;
    localparam int WORD_W = LANE_W * LANES;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t s1_data;
        logic  s1_vld;
        word_t s2_data;
        logic  s2_vld;
    } rd_pipe_t;
endpackage

// File: rtl/bsram_addr_ctr.sv
module bsram_addr_ctr #(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              por,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              ld_n,
    input  logic              adv_n,
    input  logic              clr_n,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [ADDR_W-1:0] addr_q
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
    } ctr_t;

    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    ctr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!clr_n) begin
            st_d.addr = '0;
        end else if (!ld_n) begin
            st_d.addr = ext_addr;
        end else if (!adv_n) begin
            st_d.addr = st_q.addr + ONE;
        end
        acc_addr = st_d.addr;
        if (por) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign addr_q = st_q.addr;
endmodule

// File: rtl/bsram_array.sv
module bsram_array
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  lane_we,
    input  word_t             wdata,
    output word_t             rd_word
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (lane_we[g]) begin
                cells[addr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        assign rd_word[g*LANE_W +: LANE_W] = cells[addr];
    end
endmodule

// File: rtl/bsram_rd_pipe.sv
module bsram_rd_pipe
    import bsram_pkg::*;
(
    input  logic  clk,
    input  logic  por,
    input  logic  pipe_mode,
    input  logic  rd_en,
    input  word_t rd_word,
    output word_t rdata,
    output logic  rvalid
);
    rd_pipe_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.s1_data = rd_word;
        st_d.s1_vld  = rd_en;
        st_d.s2_data = st_q.s1_data;
        st_d.s2_vld  = st_q.s1_vld;
        if (por) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    always_comb begin
        if (pipe_mode) begin
            rdata  = st_q.s2_data;
            rvalid = st_q.s2_vld;
        end else begin
            rdata  = st_q.s1_data;
            rvalid = st_q.s1_vld;
        end
    end
endmodule

// File: rtl/bsram_port.sv
module bsram_port
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              por,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              ld_n,
    input  logic              adv_n,
    input  logic              clr_n,
    input  logic              cs_n,
    input  logic              cs,
    input  logic              wr_n,
    input  logic [LANES-1:0]  lane_n,
    input  logic              oe_n,
    input  logic              pipe_mode,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic              rvalid
);
    logic [ADDR_W-1:0] acc_addr;
    logic [ADDR_W-1:0] addr_q;
    logic              chip_sel;
    logic              wr_cyc;
    logic [LANES-1:0]  lane_we;
    logic              rd_en;
    word_t             rd_word;

    bsram_addr_ctr #(.ADDR_W(ADDR_W)) ctr_i (
        .clk      (clk),
        .por      (por),
        .ext_addr (ext_addr),
        .ld_n     (ld_n),
        .adv_n    (adv_n),
        .clr_n    (clr_n),
        .acc_addr (acc_addr),
        .addr_q   (addr_q)
    );

    always_comb begin
        chip_sel = !cs_n && cs;
        wr_cyc   = chip_sel && !wr_n;
        lane_we  = ~lane_n & {LANES{wr_cyc}};
        rd_en    = chip_sel && wr_n && !oe_n && (lane_n != {LANES{1'b1}});
    end

    bsram_array #(.ADDR_W(ADDR_W)) mem_i (
        .clk     (clk),
        .addr    (acc_addr),
        .lane_we (lane_we),
        .wdata   (wdata),
        .rd_word (rd_word)
    );

    bsram_rd_pipe rdp_i (
        .clk       (clk),
        .por       (por),
        .pipe_mode (pipe_mode),
        .rd_en     (rd_en),
        .rd_word   (rd_word),
        .rdata     (rdata),
        .rvalid    (rvalid)
    );
endmodule

// File: rtl/bsram_port_chk.sv
module bsram_port_chk #(
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              por,
    input logic [ADDR_W-1:0] ext_addr,
    input logic              ld_n,
    input logic              adv_n,
    input logic              clr_n,
    input logic              cs_n,
    input logic              cs,
    input logic              wr_n,
    input logic              oe_n,
    input logic              pipe_mode,
    input logic              rvalid,
    input logic [ADDR_W-1:0] addr_q
);
    assert_clear_to_zero_R1: assert property (@(posedge clk) disable iff (por)
        !clr_n |=> addr_q == '0);

    assert_load_takes_pins_R2: assert property (@(posedge clk) disable iff (por)
        clr_n && !ld_n |=> addr_q == $past(ext_addr));

    assert_step_by_one_R3: assert property (@(posedge clk) disable iff (por)
        clr_n && ld_n && !adv_n |=> addr_q == $past(addr_q) + 1'b1);

    assert_hold_keeps_R4: assert property (@(posedge clk) disable iff (por)
        clr_n && ld_n && adv_n |=> $stable(addr_q));

    assert_oe_off_silent_R6: assert property (@(posedge clk) disable iff (por)
        !pipe_mode && $past(oe_n) |-> !rvalid);

    assert_write_silent_R6: assert property (@(posedge clk) disable iff (por)
        !pipe_mode && $past(!wr_n) |-> !rvalid);

    assert_deselect_silent_R6: assert property (@(posedge clk) disable iff (por)
        !pipe_mode && $past(cs_n || !cs) |-> !rvalid);

    assert_reset_state_R9: assert property (@(posedge clk)
        por |=> !rvalid && addr_q == '0);
endmodule

bind bsram_port bsram_port_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .por       (por),
    .ext_addr  (ext_addr),
    .ld_n      (ld_n),
    .adv_n     (adv_n),
    .clr_n     (clr_n),
    .cs_n      (cs_n),
    .cs        (cs),
    .wr_n      (wr_n),
    .oe_n      (oe_n),
    .pipe_mode (pipe_mode),
    .rvalid    (rvalid),
    .addr_q    (addr_q)
);

// File: tb/bsram_port_tb.sv
module bsram_port_tb_top;
    localparam int AW = 5;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          por = 1'b1;
    logic [AW-1:0] ext_addr = '0;
    logic          ld_n = 1'b1, adv_n = 1'b1, clr_n = 1'b1;
    logic          cs_n = 1'b1, cs = 1'b0, wr_n = 1'b1, oe_n = 1'b1;
    logic [1:0]    lane_n = 2'b11;
    logic          pipe_mode = 1'b0;
    logic [17:0]   wdata = '0;
    logic [17:0]   rdata;
    logic          rvalid;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;

    typedef struct {
        int          due;
        logic        vld;
        logic [17:0] data;
        string       tag;
    } exp_t;
    exp_t sb[$];

    logic [17:0]   ref_mem [DEPTH];
    logic [AW-1:0] ref_addr = '0;

    bsram_port #(.ADDR_W(AW)) dut_i (
        .clk(clk), .por(por), .ext_addr(ext_addr), .ld_n(ld_n), .adv_n(adv_n),
        .clr_n(clr_n), .cs_n(cs_n), .cs(cs), .wr_n(wr_n), .lane_n(lane_n),
        .oe_n(oe_n), .pipe_mode(pipe_mode), .wdata(wdata), .rdata(rdata),
        .rvalid(rvalid)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: pops expected items when due
    always @(posedge clk) begin
        #2;
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].due == cyc) begin
                checks++;
                if (rvalid !== sb[i].vld || (sb[i].vld && rdata !== sb[i].data)) begin
                    errors++;
                    $display("FAIL %s: actual vld=%0b data=%h expected vld=%0b data=%h",
                             sb[i].tag, rvalid, rdata, sb[i].vld, sb[i].data);
                end
                sb.delete(i);
            end
        end
    end

    // driver: one access; ctl = {clr_n, ld_n, adv_n}
    task automatic step(input logic [2:0] ctl, input logic [AW-1:0] ea,
                        input logic sel, input logic wn, input logic [1:0] ln,
                        input logic oen, input logic [17:0] wd,
                        input bit chk, input string tag);
        exp_t e;
        logic [17:0] old;
        @(negedge clk);
        {clr_n, ld_n, adv_n} = ctl;
        ext_addr = ea;
        cs_n = !sel; cs = sel; wr_n = wn; lane_n = ln; oe_n = oen; wdata = wd;
        if (!ctl[2])      ref_addr = '0;
        else if (!ctl[1]) ref_addr = ea;
        else if (!ctl[0]) ref_addr = ref_addr + 1'b1;
        old = ref_mem[ref_addr];
        if (sel && !wn) begin
            if (!ln[0]) ref_mem[ref_addr][8:0]  = wd[8:0];
            if (!ln[1]) ref_mem[ref_addr][17:9] = wd[17:9];
        end
        if (chk) begin
            e.due  = cyc + (pipe_mode ? 2 : 1);
            e.vld  = sel && wn && !oen && (ln != 2'b11);
            e.data = old;
            e.tag  = tag;
            sb.push_back(e);
        end
    endtask

    task automatic set_mode(input logic m);
        step(3'b111, '0, 1'b0, 1'b1, 2'b11, 1'b1, '0, 1'b0, "");
        step(3'b111, '0, 1'b0, 1'b1, 2'b11, 1'b1, '0, 1'b0, "");
        @(negedge clk);
        pipe_mode = m;
        step(3'b111, '0, 1'b0, 1'b1, 2'b11, 1'b1, '0, 1'b0, "");
        step(3'b111, '0, 1'b0, 1'b1, 2'b11, 1'b1, '0, 1'b0, "");
    endtask

    function automatic logic [17:0] pat(input int a);
        return 18'h2A000 ^ 18'(a * 18'h0A5 + 3);
    endfunction

    initial begin
        #100000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        checks++;
        if (rvalid !== 1'b0) begin
            errors++;
            $display("FAIL R9: actual rvalid=%0b expected 0", rvalid);
        end
        por = 1'b0;
        // R9: address 0 after reset, written with hold
        step(3'b111, 5'd9, 1'b1, 1'b0, 2'b00, 1'b0, pat(0), 1'b1, "R9 write at reset address");
        // R2/R3 fill 1..31: load then step
        step(3'b101, 5'd1, 1'b1, 1'b0, 2'b00, 1'b0, pat(1), 1'b1, "R2 load write");
        for (int a = 2; a < DEPTH; a++)
            step(3'b110, '0, 1'b1, 1'b0, 2'b00, 1'b0, pat(a), 1'b1, "R3 step write");
        // R2/R7 reads walk
        step(3'b101, 5'd0, 1'b1, 1'b1, 2'b00, 1'b0, '0, 1'b1, "R2 R7 R9 load read 0");
        for (int a = 1; a < DEPTH; a++)
            step(3'b110, '0, 1'b1, 1'b1, 2'b00, 1'b0, '0, 1'b1, "R3 R7 step read");
        step(3'b110, '0, 1'b1, 1'b1, 2'b00, 1'b0, '0, 1'b1, "R3 wrap to 0");
        // R4 hold
        step(3'b101, 5'd17, 1'b1, 1'b1, 2'b00, 1'b0, '0, 1'b1, "R2 load 17");
        step(3'b111, 5'd3, 1'b1, 1'b1, 2'b00, 1'b0, '0, 1'b1, "R4 hold");
        step(3'b111, 5'd3, 1'b1, 1'b1, 2'b01, 1'b0, '0, 1'b1, "R4 hold again");
        // R1 priority over load and step
        step(3'b000, 5'd12, 1'b1, 1'b1, 2'b00, 1'b0, '0, 1'b1, "R1 clear beats load");
        step(3'b010, 5'd12, 1'b1, 1'b1, 2'b00, 1'b0, '0, 1'b1, "R1 clear beats step");
        step(3'b100, 5'd6, 1'b1, 1'b1, 2'b00, 1'b0, '0, 1'b1, "R2 load beats step");
        // R2 load while deselected, then hold read
        step(3'b101, 5'd22, 1'b0, 1'b1, 2'b11, 1'b0, '0, 1'b1, "R2 load deselected");
        step(3'b111, '0, 1'b1, 1'b1, 2'b00, 1'b0, '0, 1'b1, "R2 readback of load");
        // R3 step while deselected and lanes off
        step(3'b110, '0, 1'b0, 1'b1, 2'b11, 1'b0, '0, 1'b1, "R3 step deselected");
        step(3'b110, '0, 1'b1, 1'b1, 2'b11, 1'b0, '0, 1'b1, "R3 R6 step lanes off");
        step(3'b111, '0, 1'b1, 1'b1, 2'b00, 1'b0, '0, 1'b1, "R3 readback of step");
        // R3 wrap by load 31 then step
        step(3'b101, 5'd31, 1'b0, 1'b1, 2'b11, 1'b0, '0, 1'b1, "R3 load top");
        step(3'b110, '0, 1'b1, 1'b1, 2'b00, 1'b0, '0, 1'b1, "R3 top wraps to 0");
        // R5 byte lanes
        step(3'b101, 5'd10, 1'b1, 1'b0, 2'b10, 1'b0, 18'h00000, 1'b1, "R5 lower lane write");
        step(3'b111, '0, 1'b1, 1'b1, 2'b00, 1'b0, '0, 1'b1, "R5 lower lane only");
        step(3'b111, '0, 1'b1, 1'b0, 2'b01, 1'b0, 18'h3FFFF, 1'b1, "R5 upper lane write");
        step(3'b111, '0, 1'b1, 1'b1, 2'b00, 1'b0, '0, 1'b1, "R5 upper lane only");
        step(3'b111, '0, 1'b1, 1'b0, 2'b11, 1'b0, 18'h12345, 1'b1, "R5 no lane write");
        step(3'b111, '0, 1'b1, 1'b1, 2'b00, 1'b0, '0, 1'b1, "R5 no lane unchanged");
        step(3'b111, '0, 1'b0, 1'b0, 2'b00, 1'b0, 18'h0F0F0, 1'b1, "R5 deselected write");
        step(3'b111, '0, 1'b1, 1'b1, 2'b00, 1'b0, '0, 1'b1, "R5 deselected unchanged");
        // R6 qualifications
        step(3'b111, '0, 1'b1, 1'b1, 2'b00, 1'b1, '0, 1'b1, "R6 oe off");
        step(3'b111, '0, 1'b0, 1'b1, 2'b00, 1'b0, '0, 1'b1, "R6 deselected");
        step(3'b111, '0, 1'b1, 1'b1, 2'b11, 1'b0, '0, 1'b1, "R6 lanes off");
        step(3'b101, 5'd4, 1'b1, 1'b0, 2'b00, 1'b0, 18'h2BEEF, 1'b1, "R6 write cycle");
        step(3'b111, '0, 1'b1, 1'b1, 2'b10, 1'b0, '0, 1'b1, "R6 R5 one lane read");
        // R8 pipelined
        set_mode(1'b1);
        step(3'b101, 5'd20, 1'b1, 1'b1, 2'b00, 1'b0, '0, 1'b1, "R8 pipe load read");
        for (int a = 0; a < 6; a++)
            step(3'b110, '0, 1'b1, 1'b1, 2'b00, (a == 2), '0, 1'b1, "R8 pipe step read");
        step(3'b111, '0, 1'b1, 1'b0, 2'b00, 1'b0, 18'h1C3C3, 1'b1, "R8 R6 pipe write");
        step(3'b111, '0, 1'b1, 1'b1, 2'b00, 1'b0, '0, 1'b1, "R8 pipe readback");
        step(3'b011, '0, 1'b1, 1'b1, 2'b00, 1'b0, '0, 1'b1, "R8 R1 pipe clear read");
        step(3'b111, '0, 1'b0, 1'b1, 2'b00, 1'b0, '0, 1'b1, "R8 R6 pipe deselected");
        set_mode(1'b0);
        step(3'b101, 5'd20, 1'b1, 1'b1, 2'b00, 1'b0, '0, 1'b1, "R7 flow again");
        repeat (4) @(negedge clk);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule